// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one character, written by software into a single holding buffer, into one asynchronous serial frame. The line idles high. A frame is a low start bit, then the data bits least significant first, then an optional parity bit, then high stop bits. The line moves on by exactly one bit for each pulse of an external one-per-bit baud tick.

A two-bit length code selects seven, eight or nine data bits, or a loopback setting. Loopback uses nine-bit framing and sends the serial stream to an internal receiver-side output, while the external line stays high. In the 7- and 8-bit settings an optional parity bit follows the data. It can be odd, even, forced one or forced zero. In the nine-bit settings parity cannot be used. Instead, a control bit that is shared with the low parity-select position supplies the ninth data bit.

A buffer-empty flag tells software when it may write the next character. Characters that are queued in time follow each other with no idle gap between frames.

Top module: `usart_tx_frame`

## Requirements
- R1: After reset, `tx_line` and `loop_line` are high and `buf_empty` is 1.
- R2: A write (`wr_en` high for one cycle) makes `buf_empty` 0 from the next cycle. When the character moves into the shifter at a baud tick (the start bit begins), `buf_empty` returns to 1.
- R3: With the buffer full and the shifter idle, the start bit (low) appears after the next `baud_tick`. Each later tick advances by exactly one bit, and the line does not change between ticks. After the last stop bit (high, STOP_BITS of them) the line idles high.
- R4: `cfg_len` 00 sends eight data bits and 01 sends the low seven bits of the buffer. Data is sent least significant bit first.
- R5: In the 7- and 8-bit settings with `cfg_par_en`=1, one parity bit follows the data. The select code {`cfg_par_hi`,`cfg_shared`} means: 00 odd (data plus parity has an odd number of ones), 01 even, 10 constant 1, 11 constant 0.
- R6: With `cfg_len`=10, nine data bits are sent: the eight buffer bits, then `cfg_shared` as the ninth. `cfg_par_en` has no effect.
- R7: With `cfg_len`=11 (loopback), the nine-bit frame of R6 appears on `loop_line` and `tx_line` stays high. In all other settings `loop_line` stays high.
- R8: If the buffer is full when the stop-bit period ends, the next start bit follows on the very next tick with no idle bit.
- R9: The control inputs are captured when the start bit begins. Changing them during a frame does not alter that frame.
- R10: A write while the buffer is already full replaces the waiting character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 2 | Frame length / loopback code |
| cfg_par_en | input | 1 | Parity enable (7/8-bit settings) |
| cfg_par_hi | input | 1 | High parity-select bit |
| cfg_shared | input | 1 | Low parity-select bit, or ninth data bit |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | CHAR_W | Character to buffer |
| baud_tick | input | 1 | One pulse per bit time |
| tx_line | output | 1 | External serial line |
| loop_line | output | 1 | Internal loopback line to receiver |
| buf_empty | output | 1 | Holding buffer empty |

## Verification
Each internal fault shows up on the serial line within one bit time. A wrong bit counter either drops or repeats a stop bit, or moves the next start bit by whole ticks. A wrong parity or length decode corrupts one specific bit position of the frame. A stuck buffer flag either makes `buf_empty` disagree in the cycle after a write or start, or sends a stale character. The bench compares every bit of every frame in a full sweep of length code, parity enable, select code and data pattern. It also checks the line at the tick after the last stop bit, so gaps and overruns are caught at the boundary where they occur.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;

   typedef enum logic [1:0] {
      LEN_EIGHT = 2'b00,
      LEN_SEVEN = 2'b01,
      LEN_NINE  = 2'b10,
      LEN_LOOP  = 2'b11
   } len_code_e;

   typedef enum logic [1:0] {
      PAR_ODD   = 2'b00,
      PAR_EVEN  = 2'b01,
      PAR_MARK  = 2'b10,
      PAR_SPACE = 2'b11
   } par_kind_e;

   typedef struct packed {
      len_code_e len;
      logic      par_en;
      logic      par_hi;
      logic      shared_bit;
   } tx_cfg_t;

endpackage

// File: rtl/usart_tx_parity.sv
module usart_tx_parity #(
   parameter int CHAR_W = 8
) (
   input  logic [CHAR_W-1:0]        data,
   input  logic                     short_char,
   input  usart_tx_pkg::par_kind_e  kind,
   output logic                     par_bit
);
   import usart_tx_pkg::*;

   logic [CHAR_W-1:0] chain;

   // running XOR; tap one position early for the short character
   assign chain[0] = data[0];
   generate
      for (genvar i = 1; i < CHAR_W; i++) begin : g_chain
         assign chain[i] = chain[i-1] ^ data[i];
      end
   endgenerate

   logic ones_odd;
   assign ones_odd = short_char ? chain[CHAR_W-2] : chain[CHAR_W-1];

   always_comb begin
      unique case (kind)
         PAR_ODD:   par_bit = ~ones_odd;
         PAR_EVEN:  par_bit = ones_odd;
         PAR_MARK:  par_bit = 1'b1;
         default:   par_bit = 1'b0;
      endcase
   end

endmodule

// File: rtl/usart_tx_fmt.sv
module usart_tx_fmt #(
   parameter int CHAR_W    = 8,
   parameter int STOP_BITS = 1,
   parameter int FRAME_W   = 1 + CHAR_W + 1 + STOP_BITS,
   parameter int CNT_W     = $clog2(FRAME_W + 1)
) (
   input  usart_tx_pkg::tx_cfg_t cfg,
   input  logic [CHAR_W-1:0]     data,
   output logic [FRAME_W-1:0]    frame,
   output logic [CNT_W-1:0]      frame_len,
   output logic                  is_loop
);
   import usart_tx_pkg::*;

   logic      nine_mode;
   logic      short_char;
   logic      par_bit;
   par_kind_e kind;

   assign nine_mode  = cfg.len[1];
   assign short_char = (cfg.len == LEN_SEVEN);
   assign is_loop    = (cfg.len == LEN_LOOP);
   assign kind       = par_kind_e'({cfg.par_hi, cfg.shared_bit});

   usart_tx_parity #(.CHAR_W(CHAR_W)) u_par (
      .data       (data),
      .short_char (short_char),
      .kind       (kind),
      .par_bit    (par_bit)
   );

   always_comb begin
      int nd;
      int extra;
      frame    = '1;
      frame[0] = 1'b0;
      nd       = short_char ? CHAR_W - 1 : CHAR_W;
      extra    = 0;
      for (int i = 0; i < CHAR_W; i++) begin
         if (i < nd) frame[1+i] = data[i];
      end
      if (nine_mode) begin
         frame[1+CHAR_W] = cfg.shared_bit;
         extra = 1;
      end else if (cfg.par_en) begin
         frame[1+nd] = par_bit;
         extra = 1;
      end
      frame_len = CNT_W'(1 + nd + extra + STOP_BITS);
   end

endmodule

// File: rtl/usart_tx_hold.sv
module usart_tx_hold #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CHAR_W-1:0] wr_data,
   input  logic              take,
   output logic [CHAR_W-1:0] data_q,
   output logic              full_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full_q <= 1'b0;
      end else begin
         if (wr_en) data_q <= wr_data;
         if (wr_en)      full_q <= 1'b1;
         else if (take)  full_q <= 1'b0;
      end
   end

   AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> full_q);  // R2
   AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !wr_en) |=> !full_q);  // R2
   AST_LAST_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (data_q == $past(wr_data)));  // R10

endmodule

// File: rtl/usart_tx_serial.sv
module usart_tx_serial #(
   parameter int FRAME_W   = 11,
   parameter int CNT_W     = 4,
   parameter int MIN_LEN   = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               have_char,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic [CNT_W-1:0]   len_in,
   input  logic               loop_in,
   output logic               load,
   output logic               busy_q,
   output logic               loop_q,
   output logic               bit_o
);

   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   left;
   logic               last_bit;

   assign last_bit = (left == CNT_W'(1));
   assign load     = tick && have_char && (!busy_q || last_bit);
   assign bit_o    = busy_q ? shreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '1;
         left   <= '0;
         busy_q <= 1'b0;
         loop_q <= 1'b0;
      end else if (load) begin
         shreg  <= frame_in;
         left   <= len_in;
         busy_q <= 1'b1;
         loop_q <= loop_in;
      end else if (tick && busy_q) begin
         if (last_bit) begin
            shreg  <= '1;
            left   <= '0;
            busy_q <= 1'b0;
         end else begin
            shreg  <= {1'b1, shreg[FRAME_W-1:1]};
            left   <= left - CNT_W'(1);
         end
      end
   end

   AST_STEADY_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(bit_o));  // R3
   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (bit_o == 1'b0));  // R3
   AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (len_in >= CNT_W'(MIN_LEN) && len_in <= CNT_W'(FRAME_W)));  // R4

endmodule

// File: rtl/usart_tx_frame.sv
module usart_tx_frame #(
   parameter int CHAR_W    = 8,
   parameter int STOP_BITS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_len,
   input  logic              cfg_par_en,
   input  logic              cfg_par_hi,
   input  logic              cfg_shared,
   input  logic              wr_en,
   input  logic [CHAR_W-1:0] wr_data,
   input  logic              baud_tick,
   output logic              tx_line,
   output logic              loop_line,
   output logic              buf_empty
);
   import usart_tx_pkg::*;

   localparam int FRAME_W = 1 + CHAR_W + 1 + STOP_BITS;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam int MIN_LEN = 1 + (CHAR_W - 1) + STOP_BITS;

   generate
      if (CHAR_W < 2) begin : g_bad_width
         $error("CHAR_W must be at least 2");
      end
      if (STOP_BITS < 1 || STOP_BITS > 2) begin : g_bad_stop
         $error("STOP_BITS must be 1 or 2");
      end
   endgenerate

   tx_cfg_t             cfg;
   logic [CHAR_W-1:0]   held;
   logic                full;
   logic                take;
   logic [FRAME_W-1:0]  frame;
   logic [CNT_W-1:0]    flen;
   logic                is_loop;
   logic                busy;
   logic                loop_q;
   logic                ser_bit;

   assign cfg = '{len: len_code_e'(cfg_len), par_en: cfg_par_en,
                  par_hi: cfg_par_hi, shared_bit: cfg_shared};

   usart_tx_hold #(.CHAR_W(CHAR_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (take),
      .data_q  (held),
      .full_q  (full)
   );

   usart_tx_fmt #(
      .CHAR_W    (CHAR_W),
      .STOP_BITS (STOP_BITS),
      .FRAME_W   (FRAME_W),
      .CNT_W     (CNT_W)
   ) u_fmt (
      .cfg       (cfg),
      .data      (held),
      .frame     (frame),
      .frame_len (flen),
      .is_loop   (is_loop)
   );

   usart_tx_serial #(
      .FRAME_W (FRAME_W),
      .CNT_W   (CNT_W),
      .MIN_LEN (MIN_LEN)
   ) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick),
      .have_char (full),
      .frame_in  (frame),
      .len_in    (flen),
      .loop_in   (is_loop),
      .load      (take),
      .busy_q    (busy),
      .loop_q    (loop_q),
      .bit_o     (ser_bit)
   );

   assign tx_line   = loop_q ? 1'b1 : ser_bit;
   assign loop_line = loop_q ? ser_bit : 1'b1;
   assign buf_empty = ~full;

   AST_ONE_LINE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_line |-> loop_line);  // R7
   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (tx_line && loop_line));  // R3
   AST_START_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !wr_en) |=> buf_empty);  // R2

endmodule

// File: tb/usart_tx_frame_test.sv
module usart_tx_frame_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_len = 2'b00;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_hi = 1'b0;
   logic       cfg_shared = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       baud_tick = 1'b0;
   logic       tx_line;
   logic       loop_line;
   logic       buf_empty;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   usart_tx_frame #(.CHAR_W(8), .STOP_BITS(1)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_len    (cfg_len),
      .cfg_par_en (cfg_par_en),
      .cfg_par_hi (cfg_par_hi),
      .cfg_shared (cfg_shared),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .baud_tick  (baud_tick),
      .tx_line    (tx_line),
      .loop_line  (loop_line),
      .buf_empty  (buf_empty)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
   endtask

   task automatic write(input logic [7:0] d);
      @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
      @(negedge clk) wr_en = 1'b0;
   endtask

   task automatic set_cfg(input int len, input int pe, input int sel, input int sh9);
      cfg_len    = 2'(len);
      cfg_par_en = 1'(pe);
      cfg_par_hi = 1'(sel >> 1);
      cfg_shared = (len >= 2) ? 1'(sh9) : 1'(sel & 1);
   endtask

   // expected frame: bit list and count, computed from the requirement text
   task automatic expect_frame(input int len, input int pe, input int sel,
                               input int sh9, input logic [7:0] d,
                               output logic exp_bits [0:15], output int n);
      int nd;
      int ones;
      nd = (len == 1) ? 7 : (len == 0) ? 8 : 9;
      n = 0;
      ones = 0;
      exp_bits[n++] = 1'b0;
      for (int i = 0; i < nd; i++) begin
         logic b;
         b = (i < 8) ? d[i] : 1'(sh9);
         exp_bits[n++] = b;
         ones += int'(b);
      end
      if (len < 2 && pe != 0) begin
         case (sel)
            0: exp_bits[n++] = ((ones % 2) == 0);
            1: exp_bits[n++] = ((ones % 2) == 1);
            2: exp_bits[n++] = 1'b1;
            default: exp_bits[n++] = 1'b0;
         endcase
      end
      exp_bits[n++] = 1'b1;
   endtask

   function automatic string tag_of(input int len, input int pe);
      if (len == 3) return "R7";
      if (len == 2) return "R6";
      if (pe != 0)  return "R5";
      return "R4";
   endfunction

   // sends one frame from idle and checks every bit plus the idle after
   task automatic run_frame(input int len, input int pe, input int sel,
                            input int sh9, input logic [7:0] d);
      logic eb [0:15];
      int n;
      string tg;
      expect_frame(len, pe, sel, sh9, d, eb, n);
      tg = tag_of(len, pe);
      set_cfg(len, pe, sel, sh9);
      write(d);
      check("R2", int'(buf_empty), 0);
      for (int k = 0; k < n; k++) begin
         tick();
         if (k == 0) check("R2", int'(buf_empty), 1);
         if (len == 3) begin
            check(tg, int'(loop_line), int'(eb[k]));
            check("R7", int'(tx_line), 1);
         end else begin
            check(tg, int'(tx_line), int'(eb[k]));
            check("R7", int'(loop_line), 1);
         end
      end
      tick();
      check("R3", int'(tx_line & loop_line), 1);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] pats [0:5];
      logic eb [0:15];
      int n;
      pats = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81, 8'h7E};

      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", int'(tx_line), 1);
      check("R1", int'(loop_line), 1);
      check("R1", int'(buf_empty), 1);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(buf_empty), 1);

      // R3: a tick without a character leaves the line idle
      tick();
      check("R3", int'(tx_line), 1);

      // sweep of length code, parity enable, select code and data pattern
      for (int len = 0; len < 4; len++)
         for (int pe = 0; pe < 2; pe++)
            for (int sel = 0; sel < 4; sel++)
               for (int p = 0; p < 6; p++)
                  run_frame(len, pe, sel, (p + sel) & 1, pats[p]);

      // R3: the line holds between ticks
      set_cfg(0, 0, 0, 0);
      write(8'h01);
      tick();
      repeat (5) @(negedge clk);
      check("R3", int'(tx_line), 0);
      tick();
      check("R3", int'(tx_line), 1);
      for (int k = 0; k < 9; k++) tick();
      check("R3", int'(tx_line), 1);

      // R8: back-to-back frames with no idle bit in between
      set_cfg(0, 1, 1, 0);
      write(8'h55);
      tick();
      write(8'hC3);
      check("R8", int'(buf_empty), 0);
      expect_frame(0, 1, 1, 0, 8'h55, eb, n);
      for (int k = 1; k < n; k++) begin
         tick();
         check("R8", int'(tx_line), int'(eb[k]));
      end
      tick();
      check("R8", int'(tx_line), 0);
      check("R8", int'(buf_empty), 1);
      expect_frame(0, 1, 1, 0, 8'hC3, eb, n);
      for (int k = 1; k < n; k++) begin
         tick();
         check("R8", int'(tx_line), int'(eb[k]));
      end
      tick();
      check("R8", int'(tx_line), 1);

      // R9: control changes during a frame do not alter it
      set_cfg(0, 0, 0, 0);
      write(8'h0F);
      tick();
      set_cfg(2, 1, 3, 1);
      expect_frame(0, 0, 0, 0, 8'h0F, eb, n);
      for (int k = 1; k < n; k++) begin
         tick();
         check("R9", int'(tx_line), int'(eb[k]));
      end
      tick();
      check("R9", int'(tx_line), 1);

      // R10: a second write before the start replaces the character
      set_cfg(0, 0, 0, 0);
      write(8'h11);
      write(8'h96);
      check("R10", int'(buf_empty), 0);
      expect_frame(0, 0, 0, 0, 8'h96, eb, n);
      for (int k = 0; k < n; k++) begin
         tick();
         check("R10", int'(tx_line), int'(eb[k]));
      end
      tick();
      check("R10", int'(buf_empty), 1);
      check("R10", int'(tx_line), 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule